// File: doc/BRIEF.md
# Cascadable 4-bit ALU Slice and 16-bit Sliced ALU

This block is a 16-bit arithmetic-logic unit built from four identical 4-bit slices placed side by side. Each slice takes one nibble of the accumulator operand and the matching nibble of the data-bus operand. All slices share one 3-bit function code. The only signal that passes from one slice to the next is the carry, which ripples from the least significant slice toward the most significant one.

The block is purely combinational. A new result, carry out and zero flag are valid in the same cycle that the operands and the function code are applied. Bitwise operations never look outside their own bit position. Addition and subtraction are done in 4-bit groups, and the groups are joined only by the rippled carry. Subtraction inverts the bus operand inside every slice and forces a carry of 1 into the least significant slice. Logic operations pass the carry in of the whole chain straight through to its carry out.

Top module: `alu16_sliced`

## Requirements
- R1: Function code 3'b000 (add) gives {carry out, result} equal to the 17-bit sum acc + bus + carry in.
- R2: Function code 3'b001 (subtract) gives result = acc + ~bus + 1 modulo 2^16. Carry out is 1 exactly when acc >= bus as unsigned numbers. The external carry in has no effect.
- R3: Function code 3'b010 gives result = acc AND bus, bit by bit.
- R4: Function code 3'b011 gives result = acc OR bus, bit by bit.
- R5: Function code 3'b100 gives result = acc XOR bus, bit by bit.
- R6: Function code 3'b101 gives result = bus, and acc has no effect.
- R7: For codes 3'b010 through 3'b111, carry out equals the external carry in.
- R8: The zero flag is 1 exactly when all 16 result bits are 0.
- R9: The unused codes 3'b110 and 3'b111 give a result of 0.
- R10: A carry that is generated in one nibble propagates through every more significant nibble. For example, 16'h0FFF + 1 gives 16'h1000, and 16'hFFFF + 0 with carry in 1 gives 0 with carry out 1 and the zero flag set.
- R11: The outputs follow the inputs with no register stage: they are valid in the same cycle the inputs change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| i_acc | input | 16 | Accumulator operand |
| i_bus | input | 16 | Data-bus operand |
| i_func | input | 3 | Function code shared by all slices |
| i_carry | input | 1 | Carry into the least significant slice (ignored for subtract) |
| o_result | output | 16 | Result |
| o_carry | output | 1 | Carry out of the most significant slice |
| o_zero | output | 1 | High when the result is all zeros |

## Verification
The bound checker re-evaluates the operands against the outputs whenever they change. It checks the 17-bit sum for add, the forced entry carry and the difference for subtract, and the bitwise results. It also checks that the carry passes through unchanged for non-arithmetic codes, that unused codes give zero, and that the zero flag agrees with the whole result word. Carry ripple across particular nibble boundaries, the borrow sense at equal operands, and the same-cycle settling of the outputs depend on chosen operand patterns, so only the bench's directed scenarios show them.

// File: rtl/alu16_pkg.sv
package alu16_pkg;
  localparam int FUNC_W = 3;

  typedef enum logic [FUNC_W-1:0] {
    FN_ADD   = 3'b000,
    FN_SUB   = 3'b001,
    FN_AND   = 3'b010,
    FN_OR    = 3'b011,
    FN_XOR   = 3'b100,
    FN_PASSB = 3'b101
  } alu_fn_e;

  // true for codes whose carry comes from the adder
  function automatic logic fn_is_arith(input logic [FUNC_W-1:0] f);
    return (f == FN_ADD) || (f == FN_SUB);
  endfunction

  // subtract inverts the bus operand in every slice
  function automatic logic fn_inverts_bus(input logic [FUNC_W-1:0] f);
    return f == FN_SUB;
  endfunction

  // single-bit logic result, depends only on the two bits at one position
  function automatic logic bit_logic(input logic [FUNC_W-1:0] f,
                                     input logic a, input logic b);
    case (f)
      FN_AND:   return a & b;
      FN_OR:    return a | b;
      FN_XOR:   return a ^ b;
      FN_PASSB: return b;
      default:  return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/alu_chain_entry.sv
module alu_chain_entry
  import alu16_pkg::*;
(
  input  logic [FUNC_W-1:0] func,
  input  logic              ext_cin,
  output logic              chain_cin
);
  // subtract needs the +1 of two's complement at the bottom of the chain
  assign chain_cin = fn_inverts_bus(func) ? 1'b1 : ext_cin;
endmodule

// File: rtl/alu_slice.sv
module alu_slice
  import alu16_pkg::*;
#(
  parameter int W = 4
) (
  input  logic [W-1:0]      acc,
  input  logic [W-1:0]      bus,
  input  logic [FUNC_W-1:0] func,
  input  logic              cin,
  output logic [W-1:0]      res,
  output logic              cout,
  output logic              nib_zero
);
  logic [W-1:0] bus_eff;
  logic [W:0]   sum;
  logic [W-1:0] logic_res;

  assign bus_eff = fn_inverts_bus(func) ? ~bus : bus;
  assign sum     = {1'b0, acc} + {1'b0, bus_eff} + {{W{1'b0}}, cin};

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign logic_res[i] = bit_logic(func, acc[i], bus[i]);
  end

  always_comb begin
    if (fn_is_arith(func)) begin
      res  = sum[W-1:0];
      cout = sum[W];
    end else begin
      res  = logic_res;
      cout = cin;
    end
  end

  assign nib_zero = ~|res;
endmodule

// File: rtl/alu_zero_tree.sv
module alu_zero_tree #(
  parameter int N = 4
) (
  input  logic [N-1:0] part_zero,
  output logic         all_zero
);
  assign all_zero = &part_zero;
endmodule

// File: rtl/alu16_sliced.sv
module alu16_sliced
  import alu16_pkg::*;
#(
  parameter int SLICE_W    = 4,
  parameter int NUM_SLICES = 4,
  localparam int DW        = SLICE_W * NUM_SLICES
) (
  input  logic [DW-1:0]     i_acc,
  input  logic [DW-1:0]     i_bus,
  input  logic [FUNC_W-1:0] i_func,
  input  logic              i_carry,
  output logic [DW-1:0]     o_result,
  output logic              o_carry,
  output logic              o_zero
);
  // carry_chain[k] enters slice k; carry_chain[NUM_SLICES] leaves the top
  logic [NUM_SLICES:0]   carry_chain;
  logic [NUM_SLICES-1:0] slice_zero;

  alu_chain_entry u_entry (
    .func      (i_func),
    .ext_cin   (i_carry),
    .chain_cin (carry_chain[0])
  );

  for (genvar k = 0; k < NUM_SLICES; k++) begin : g_slice
    alu_slice #(.W(SLICE_W)) u_slice (
      .acc      (i_acc[k*SLICE_W +: SLICE_W]),
      .bus      (i_bus[k*SLICE_W +: SLICE_W]),
      .func     (i_func),
      .cin      (carry_chain[k]),
      .res      (o_result[k*SLICE_W +: SLICE_W]),
      .cout     (carry_chain[k+1]),
      .nib_zero (slice_zero[k])
    );
  end

  alu_zero_tree #(.N(NUM_SLICES)) u_zero (
    .part_zero (slice_zero),
    .all_zero  (o_zero)
  );

  assign o_carry = carry_chain[NUM_SLICES];
endmodule

// File: rtl/alu16_sliced_chk.sv
module alu16_sliced_chk
  import alu16_pkg::*;
#(
  parameter int DW = 16
) (
  input logic [DW-1:0]     acc,
  input logic [DW-1:0]     bus,
  input logic [FUNC_W-1:0] func,
  input logic              ext_cin,
  input logic              chain_cin,
  input logic [DW-1:0]     result,
  input logic              cout,
  input logic              zero
);
  logic [DW:0] full_sum;
  assign full_sum = {1'b0, acc} + {1'b0, bus} + {{DW{1'b0}}, ext_cin};

  always_comb begin
    // R1
    add_sum_chk: assert (func != 3'b000 || {cout, result} == full_sum)
      else $error("add mismatch");
    // R2
    sub_entry_chk: assert (func != 3'b001 || chain_cin == 1'b1)
      else $error("subtract entry carry not forced");
    // R2
    sub_diff_chk: assert (func != 3'b001 ||
                          (result == DW'(acc - bus) && cout == (acc >= bus)))
      else $error("subtract mismatch");
    // R3
    and_bits_chk: assert (func != 3'b010 || result == (acc & bus))
      else $error("and mismatch");
    // R4
    or_bits_chk: assert (func != 3'b011 || result == (acc | bus))
      else $error("or mismatch");
    // R5
    xor_bits_chk: assert (func != 3'b100 || result == (acc ^ bus))
      else $error("xor mismatch");
    // R6
    pass_bus_chk: assert (func != 3'b101 || result == bus)
      else $error("pass mismatch");
    // R7
    carry_pass_chk: assert (fn_is_arith(func) || cout == ext_cin)
      else $error("carry not passed through");
    // R8
    zero_flag_chk: assert (zero == (result == '0))
      else $error("zero flag mismatch");
    // R9
    unused_code_chk: assert (func[2:1] != 2'b11 || result == '0)
      else $error("unused code result not zero");
  end
endmodule

bind alu16_sliced alu16_sliced_chk #(.DW(DW)) u_chk (
  .acc       (i_acc),
  .bus       (i_bus),
  .func      (i_func),
  .ext_cin   (i_carry),
  .chain_cin (carry_chain[0]),
  .result    (o_result),
  .cout      (o_carry),
  .zero      (o_zero)
);

// File: tb/tb_alu16_sliced.sv
module tb_alu16_sliced;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] acc = '0;
  logic [15:0] bus = '0;
  logic [2:0]  func = '0;
  logic        cin = 1'b0;
  logic [15:0] res;
  logic        cout;
  logic        zero;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  alu16_sliced dut (
    .i_acc(acc), .i_bus(bus), .i_func(func), .i_carry(cin),
    .o_result(res), .o_carry(cout), .o_zero(zero)
  );

  // behavioural reference in plain integers
  task automatic model(input int a, input int b, input int f, input int c,
                       output int r, output int co);
    int s;
    case (f)
      0: begin s = a + b + c;              r = s % 65536; co = s / 65536; end
      1: begin s = a + (65535 - b) + 1;    r = s % 65536; co = s / 65536; end
      2: begin r = a & b; co = c; end
      3: begin r = a | b; co = c; end
      4: begin r = a ^ b; co = c; end
      5: begin r = b;     co = c; end
      default: begin r = 0; co = c; end
    endcase
  endtask

  function automatic string tag_of(input int f);
    case (f)
      0: return "R1";
      1: return "R2";
      2: return "R3";
      3: return "R4";
      4: return "R5";
      5: return "R6";
      default: return "R9";
    endcase
  endfunction

  task automatic compare(input string tag);
    int er, ec;
    model(int'(acc), int'(bus), int'(func), int'(cin), er, ec);
    checks++;
    if (int'(res) != er || int'(cout) != ec || zero != (er == 0)) begin
      errors++;
      $display("FAIL %s: func=%0d acc=%h bus=%h cin=%0d got res=%h c=%0d z=%0d exp res=%h c=%0d z=%0d",
               tag, func, acc, bus, cin, res, cout, zero, er[15:0], ec, (er == 0));
    end
  endtask

  task automatic apply(input logic [15:0] a, input logic [15:0] b,
                       input logic [2:0] f, input logic c, input string tag);
    @(negedge clk);
    acc = a; bus = b; func = f; cin = c;
    @(posedge clk);
    #1;
    compare(tag);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rst = 1'b0;
    #1;
    compare("R8 reset state");

    apply(16'h1234, 16'h4321, 3'd0, 1'b0, "R1");
    apply(16'hFFFF, 16'h0001, 3'd0, 1'b0, "R1 R8 wrap");
    apply(16'h0FFF, 16'h0001, 3'd0, 1'b0, "R10");
    apply(16'h00FF, 16'h0000, 3'd0, 1'b1, "R10");
    apply(16'hFFFF, 16'h0000, 3'd0, 1'b1, "R10 full ripple");
    apply(16'h5000, 16'h3000, 3'd1, 1'b0, "R2");
    apply(16'h3000, 16'h5000, 3'd1, 1'b1, "R2 borrow");
    apply(16'hABCD, 16'hABCD, 3'd1, 1'b0, "R2 R8 equal");
    apply(16'h0000, 16'h0001, 3'd1, 1'b1, "R2 cin ignored");
    apply(16'hF0F0, 16'hFF00, 3'd2, 1'b1, "R3 R7");
    apply(16'hF0F0, 16'h0F0F, 3'd2, 1'b0, "R3 R8");
    apply(16'hF0F0, 16'h0F0F, 3'd3, 1'b1, "R4 R7");
    apply(16'hAAAA, 16'hFFFF, 3'd4, 1'b0, "R5");
    apply(16'hAAAA, 16'hAAAA, 3'd4, 1'b1, "R5 R7 R8");
    apply(16'hFFFF, 16'h1357, 3'd5, 1'b0, "R6 acc ignored");
    apply(16'h0000, 16'h1357, 3'd5, 1'b1, "R6 R7");
    apply(16'hFFFF, 16'hFFFF, 3'd6, 1'b1, "R9 R7");
    apply(16'h1234, 16'h5678, 3'd7, 1'b0, "R9");

    // R11: outputs follow a mid-cycle input change with no clock edge
    @(negedge clk);
    acc = 16'h7FFF; bus = 16'h0001; func = 3'd0; cin = 1'b0;
    #0.5;
    compare("R11");
    acc = 16'h0F0F;  func = 3'd2;
    #0.5;
    compare("R11");

    for (int i = 0; i < 600; i++) begin
      logic [2:0] f;
      f = 3'($urandom_range(0, 7));
      apply(16'($urandom), 16'($urandom), f, 1'($urandom), tag_of(int'(f)));
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule